// File: doc/BRIEF.md
# Digital Silence Detector with Noise Test Output

This block watches two audio sample streams, one word per stream per frame, and drives one output pin. In normal operation the pin rises once both streams have carried nothing but all-zero words for a fixed run of frames. It is meant to switch an external mute transistor during digital silence, so that the analog path stays quiet. The first non-zero word on either stream takes the pin low again, and the run count starts over from zero.

A test code input can point the same pin at a free-running pseudo-random bit stream instead. This stream comes from a maximal-length linear feedback shift register that advances on a bit-rate enable. The enable runs at 128 times the sample rate, so the stream can serve as a white-noise test signal. The register and the silence counter both keep running whichever source the pin shows.

Top module: `quiet_mute_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, the silence count is zero and the noise register holds the seed (default 24'h000001), so the pin reads 0 with the flag selected and with noise selected.
- R2: Samples are taken only in cycles where `frame_stb` is high. The flag rises in the cycle after the edge that captures the 1024th consecutive frame in which both `samp_a` and `samp_b` are all zero. After 1023 such frames it is still low.
- R3: A frame strobe that carries a non-zero word on either stream clears the count. The flag is low from the following cycle, and another 1024 silent frames are needed before it rises again.
- R4: Sample values in cycles without `frame_stb` have no effect on the count or the flag.
- R5: The count saturates at 1024, so the flag stays high through any number of further silent frames.
- R6: When `test_code` equals 7 the pin carries the MSB of the noise register. Every other `test_code` value (8 bits wide) selects the silence flag.
- R7: The noise register is a 24-bit Fibonacci LFSR that moves only on edges where `bit_en` is high. Its next state is {s[22:0], s[23]^s[22]^s[21]^s[16]}, it never holds zero, and its output bit is s[23].
- R8: The silence counter and the noise register run independently of the selected source. A strobe and a bit enable in the same cycle both take effect, and switching `test_code` back shows the current flag at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe marking valid sample words |
| samp_a | input | 24 | Sample word of the first stream |
| samp_b | input | 24 | Sample word of the second stream |
| bit_en | input | 1 | Noise bit-rate enable (128 per frame) |
| test_code | input | 8 | Test register value; 7 selects noise |
| mute_o | output | 1 | Silence flag or noise bit |

## Verification
The case of interest is a frame strobe and a noise bit enable arriving in the same cycle, with the pin showing noise. The bench drives a full silent run with `bit_en` high on every strobe cycle and checks each cycle of the noise stream. It then lands a non-zero frame on a cycle that also advances the register. After each of these it switches `test_code` back to a normal value. The pin must show the flag the silence count implies, while the noise bits seen before the switch must follow the register sequence without a gap.

// File: rtl/qmg_pkg.sv
package qmg_pkg;
   typedef enum logic {
      SRC_FLAG  = 1'b0,
      SRC_NOISE = 1'b1
   } pin_src_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/qmg_silence.sv
module qmg_silence #(
   parameter int unsigned SW    = 24,
   parameter int unsigned LIMIT = 1024,
   localparam int unsigned CW   = qmg_pkg::cnt_width(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_stb,
   input  logic [SW-1:0] samp_a,
   input  logic [SW-1:0] samp_b,
   output logic [CW-1:0] count_o,
   output logic          silent_o
);
   localparam logic [CW-1:0] FULL = CW'(LIMIT);

   logic          loud;
   logic [CW-1:0] run_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("qmg_silence: LIMIT must be at least 1");
      end
      if (SW < 1) begin : g_bad_width
         $error("qmg_silence: SW must be at least 1");
      end
   endgenerate

   assign loud = (|samp_a) | (|samp_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (frame_stb) begin
         if (loud) begin
            run_q <= '0;
         end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign count_o  = run_q;
   assign silent_o = (run_q == FULL);
endmodule

// File: rtl/qmg_prbs.sv
module qmg_prbs #(
   parameter int unsigned    LW   = 24,
   parameter logic [LW-1:0] TAPS = 24'hE10000,
   parameter logic [LW-1:0] SEED = 24'h000001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [LW-1:0] state_o,
   output logic          bit_o
);
   logic [LW-1:0] sh_q;
   logic          fb;

   generate
      if (LW < 2) begin : g_bad_len
         $error("qmg_prbs: LW must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("qmg_prbs: SEED must be non-zero");
      end
      if (TAPS[LW-1] != 1'b1) begin : g_bad_taps
         $error("qmg_prbs: TAPS must include the top stage");
      end
   endgenerate

   assign fb = ^(sh_q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= SEED;
      end else if (step) begin
         sh_q <= {sh_q[LW-2:0], fb};
      end
   end

   assign state_o = sh_q;
   assign bit_o   = sh_q[LW-1];
endmodule

// File: rtl/qmg_pinmux.sv
module qmg_pinmux #(
   parameter int unsigned    TW   = 8,
   parameter logic [TW-1:0] CODE = 8'd7
) (
   input  logic [TW-1:0] test_code,
   input  logic          flag,
   input  logic          noise,
   output logic          pin_o
);
   qmg_pkg::pin_src_e src;

   assign src   = (test_code == CODE) ? qmg_pkg::SRC_NOISE : qmg_pkg::SRC_FLAG;
   assign pin_o = (src == qmg_pkg::SRC_NOISE) ? noise : flag;
endmodule

// File: rtl/quiet_mute_gen.sv
module quiet_mute_gen #(
   parameter int unsigned          SAMPLE_W      = 24,
   parameter int unsigned          SILENT_FRAMES = 1024,
   parameter int unsigned          PRBS_W        = 24,
   parameter logic [PRBS_W-1:0]    PRBS_TAPS     = 24'hE10000,
   parameter logic [PRBS_W-1:0]    PRBS_SEED     = 24'h000001,
   parameter int unsigned          TEST_W        = 8,
   parameter logic [TEST_W-1:0]    NOISE_CODE    = 8'd7,
   localparam int unsigned         CNT_W         = qmg_pkg::cnt_width(SILENT_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_stb,
   input  logic [SAMPLE_W-1:0] samp_a,
   input  logic [SAMPLE_W-1:0] samp_b,
   input  logic                bit_en,
   input  logic [TEST_W-1:0]   test_code,
   output logic                mute_o
);
   logic [CNT_W-1:0]  sil_cnt;
   logic              sil_flag;
   logic [PRBS_W-1:0] prbs_state;
   logic              prbs_bit;

   qmg_silence #(
      .SW    (SAMPLE_W),
      .LIMIT (SILENT_FRAMES)
   ) u_sil (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .samp_a    (samp_a),
      .samp_b    (samp_b),
      .count_o   (sil_cnt),
      .silent_o  (sil_flag)
   );

   qmg_prbs #(
      .LW   (PRBS_W),
      .TAPS (PRBS_TAPS),
      .SEED (PRBS_SEED)
   ) u_prbs (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (bit_en),
      .state_o (prbs_state),
      .bit_o   (prbs_bit)
   );

   qmg_pinmux #(
      .TW   (TEST_W),
      .CODE (NOISE_CODE)
   ) u_mux (
      .test_code (test_code),
      .flag      (sil_flag),
      .noise     (prbs_bit),
      .pin_o     (mute_o)
   );
endmodule

// File: rtl/qmg_checker.sv
module qmg_checker #(
   parameter int unsigned       SAMPLE_W   = 24,
   parameter int unsigned       CNT_W      = 11,
   parameter int unsigned       PRBS_W     = 24,
   parameter int unsigned       TEST_W     = 8,
   parameter logic [TEST_W-1:0] NOISE_CODE = 8'd7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_stb,
   input logic [SAMPLE_W-1:0] samp_a,
   input logic [SAMPLE_W-1:0] samp_b,
   input logic                bit_en,
   input logic [TEST_W-1:0]   test_code,
   input logic                mute_o,
   input logic [CNT_W-1:0]    sil_cnt,
   input logic                sil_flag,
   input logic [PRBS_W-1:0]   prbs_state
);
   logic loud;
   assign loud = (|samp_a) | (|samp_b);

   AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sil_flag) |-> $past(frame_stb) && !$past(loud)); // R2

   AST_CLEAR_ON_SOUND: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb && loud |=> !sil_flag && sil_cnt == '0); // R3

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(sil_cnt)); // R4

   AST_SILENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sil_flag && frame_stb && !loud |=> sil_flag); // R5

   AST_PIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      test_code != NOISE_CODE |-> mute_o == sil_flag); // R6

   AST_PIN_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
      test_code == NOISE_CODE |-> mute_o == prbs_state[PRBS_W-1]); // R6

   AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(prbs_state)); // R7

   AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_state != '0); // R7

   AST_STEP_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> prbs_state[PRBS_W-1:1] == $past(prbs_state[PRBS_W-2:0])); // R8
endmodule

bind quiet_mute_gen qmg_checker #(
   .SAMPLE_W   (SAMPLE_W),
   .CNT_W      (CNT_W),
   .PRBS_W     (PRBS_W),
   .TEST_W     (TEST_W),
   .NOISE_CODE (NOISE_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_stb  (frame_stb),
   .samp_a     (samp_a),
   .samp_b     (samp_b),
   .bit_en     (bit_en),
   .test_code  (test_code),
   .mute_o     (mute_o),
   .sil_cnt    (sil_cnt),
   .sil_flag   (sil_flag),
   .prbs_state (prbs_state)
);

// File: tb/sim_quiet_mute_gen.sv
module sim_quiet_mute_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        stb;
   logic        ben;
   logic [23:0] a;
   logic [23:0] b;
   logic [7:0]  tc;
   logic        mute;

   int          n_chk = 0;
   int          n_bad = 0;
   int          m_run = 0;
   logic [23:0] m_lfsr = 24'h000001;

   always #5 clk = ~clk;

   quiet_mute_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (stb),
      .samp_a    (a),
      .samp_b    (b),
      .bit_en    (ben),
      .test_code (tc),
      .mute_o    (mute)
   );

   task automatic chk(input string req, input logic exp);
      n_chk++;
      if (mute !== exp) begin
         n_bad++;
         $display("FAIL %s: mute_o=%b expected %b (t=%0t)", req, mute, exp, $time);
      end
   endtask

   // one clock: drive at the falling edge, step the model, land on the next falling edge
   task automatic cyc(input logic [23:0] va, input logic [23:0] vb,
                      input logic vs, input logic vben);
      a = va; b = vb; stb = vs; ben = vben;
      @(negedge clk);
      if (vs) begin
         if (va != 0 || vb != 0) m_run = 0;
         else if (m_run < 1024) m_run++;
      end
      if (vben) m_lfsr = {m_lfsr[22:0], m_lfsr[23] ^ m_lfsr[22] ^ m_lfsr[21] ^ m_lfsr[16]};
      stb = 1'b0; ben = 1'b0; a = '0; b = '0;
   endtask

   function automatic logic model_pin();
      return (tc == 8'd7) ? m_lfsr[23] : (m_run == 1024);
   endfunction

   task automatic t_reset();
      chk("R1 flag after reset", 1'b0);
      tc = 8'd7; #1;
      chk("R1 seed msb after reset", 1'b0);
      tc = 8'd0; #1;
   endtask

   task automatic t_rise();
      for (int i = 0; i < 1023; i++) cyc('0, '0, 1'b1, 1'b0);
      chk("R2 low after 1023 silent frames", 1'b0);
      cyc('0, '0, 1'b1, 1'b0);
      chk("R2 high after 1024 silent frames", 1'b1);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 2000; i++) begin
         cyc('0, '0, 1'b1, 1'b0);
         cyc('0, '0, 1'b0, 1'b0);
      end
      chk("R5 still high after 2000 more frames", 1'b1);
   endtask

   task automatic t_clear();
      cyc('0, 24'h000001, 1'b1, 1'b0);
      chk("R3 drop on stream b", 1'b0);
      for (int i = 0; i < 1023; i++) cyc('0, '0, 1'b1, 1'b0);
      chk("R3 restart needs full run (1023)", 1'b0);
      cyc('0, '0, 1'b1, 1'b0);
      chk("R3 high again after 1024", 1'b1);
      cyc(24'h800000, '0, 1'b1, 1'b0);
      chk("R3 drop on stream a negative full scale", 1'b0);
   endtask

   task automatic t_ignore();
      for (int i = 0; i < 500; i++) cyc('0, '0, 1'b1, 1'b0);
      for (int i = 0; i < 10; i++) cyc(24'h123456, 24'hFFFFFF, 1'b0, 1'b0);
      chk("R4 still low mid run", 1'b0);
      for (int i = 0; i < 524; i++) cyc('0, '0, 1'b1, 1'b0);
      chk("R4 unstrobed words did not reset run", 1'b1);
      for (int i = 0; i < 5; i++) cyc(24'h000100, 24'h000100, 1'b0, 1'b0);
      chk("R4 unstrobed words keep flag high", 1'b1);
   endtask

   task automatic t_noise();
      tc = 8'd7;
      for (int i = 0; i < 300; i++) begin
         cyc('0, '0, 1'b0, 1'b1);
         chk("R7 noise sequence", model_pin());
      end
      for (int i = 0; i < 20; i++) begin
         cyc('0, '0, 1'b0, 1'b0);
         chk("R7 hold without bit_en", model_pin());
      end
      tc = 8'd6; #1;
      chk("R6 code 6 selects flag", 1'b1);
      tc = 8'h87; #1;
      chk("R6 code 0x87 selects flag", 1'b1);
      tc = 8'hFF; #1;
      chk("R6 code 0xFF selects flag", 1'b1);
      tc = 8'd7; #1;
      chk("R6 code 7 selects noise", m_lfsr[23]);
   endtask

   task automatic t_overlap();
      tc = 8'd7;
      cyc(24'h000010, '0, 1'b1, 1'b1);
      chk("R8 noise with loud strobe", model_pin());
      for (int i = 0; i < 1024; i++) begin
         cyc('0, '0, 1'b1, 1'b1);
         chk("R8 noise during silent run", model_pin());
      end
      tc = 8'd0; #1;
      chk("R8 flag risen under noise", 1'b1);
      tc = 8'd7; #1;
      cyc('0, 24'h000002, 1'b1, 1'b1);
      chk("R8 noise on loud strobe plus step", model_pin());
      tc = 8'd0; #1;
      chk("R8 flag cleared under noise", 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; stb = 1'b0; ben = 1'b0; a = '0; b = '0; tc = 8'd0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise();
      t_saturate();
      t_clear();
      t_ignore();
      t_noise();
      t_overlap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule